// File: doc/BRIEF.md
# BCD Calendar Clock Core

This core keeps the time of day and the Gregorian calendar as packed BCD fields in two 32-bit words. The time word holds seconds, minutes and hours in 24-hour form. The calendar word holds century, year, month, weekday and day of month. Counting moves forward by one second on each cycle where the one-pulse-per-second input is high. It carries through to the day, the month, the year and the century, and the leap-year rule covers 1900 to 2099.

Software reaches the core through a flat register bus with byte offsets. Writes take effect on the clock edge and reads are combinational. To set the clock, software sets one or both update bits in the control register and waits for the acknowledge flag in the status register. It then writes the new time or calendar word and clears the update bits, after which counting resumes. Every loaded word is checked. A word that is out of range raises a flag in the validity register and is discarded.

Top module: `bcd_rtc_core`

Register offsets: 0x00 control, 0x04 mode (reads zero), 0x08 time, 0x0C calendar, 0x18 status, 0x1C status clear, 0x2C validity.

## Requirements
- R1: After reset the time word reads 0x00000000 and the calendar word reads 0x01210019, which is 1900-01-01 with weekday 1. Control, status and validity all read zero.
- R2: The time word places BCD seconds at bits 6:0, BCD minutes at bits 14:8 and BCD hours at bits 21:16. Each tick taken while not frozen adds one second. Seconds roll from 59 to 00, minutes roll from 59 to 00, and hours roll from 23 to 00, which advances the calendar by one day.
- R3: The calendar word places BCD century at bits 6:0, BCD year at bits 15:8, BCD month at bits 20:16, weekday at bits 23:21 and BCD date at bits 29:24. A day advance moves the weekday from 7 to 1. The date goes back to 01 after the last day of the month and the month moves up. Month 12 goes back to 01 and the year moves up. Year 99 goes to 00 and the century moves up, and 2099-12-31 wraps to 1900-01-01.
- R4: February has 29 days in years divisible by 4, except 1900, which has 28 days like every other year.
- R5: Writing a nonzero value to control bits 1:0 requests a freeze. Bit 0 is for time and bit 1 is for calendar. The freeze takes hold on the next tick, and that tick still counts. On that tick status bit 0, the acknowledge, goes to 1. No further tick changes the time or the calendar until both control bits are cleared.
- R6: A write to the time word is ignored unless the core is frozen and control bit 0 is set. A write to the calendar word is ignored unless the core is frozen and control bit 1 is set.
- R7: An accepted time write with any BCD digit above 9, seconds or minutes above 59, or hours above 23 sets validity bit 0 and leaves the time unchanged. An accepted time write that is valid loads the value and clears validity bit 0.
- R8: An accepted calendar write sets validity bit 1 and leaves the calendar unchanged if it has any of these faults: a BCD digit above 9, a century other than 19 or 20, a month outside 1 to 12, a weekday outside 1 to 7, or a date of 0 or beyond the days in that month. An accepted calendar write that is valid loads the value and clears validity bit 1.
- R9: Once both control bits are zero, the next tick counts forward from the loaded values.
- R10: Status bit 2 goes to 1 on every tick. Writing 1 to bit 2 of the status clear register clears it, and writing 1 to bit 0 clears the acknowledge. If a clear and a set fall in the same cycle, the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |

## Verification
A bad internal state shows up as a wrong word on the bus in the cycle right after the faulty edge. Examples are a missed BCD carry, a wrong month length or a freeze that lets a tick through. The reference model is compared against every read, so any divergence is caught the first time that register is read. Reads cycle through time, calendar and status continuously. A wrong leap decision only appears at the end of February, so those boundaries are loaded directly and rolled over with a single tick.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam logic [7:0] OFS_CTRL  = 8'h00;
  localparam logic [7:0] OFS_MODE  = 8'h04;
  localparam logic [7:0] OFS_TOD   = 8'h08;
  localparam logic [7:0] OFS_CAL   = 8'h0C;
  localparam logic [7:0] OFS_STAT  = 8'h18;
  localparam logic [7:0] OFS_SCLR  = 8'h1C;
  localparam logic [7:0] OFS_VALID = 8'h2C;

  typedef struct packed {
    logic [7:0] hr;
    logic [7:0] mn;
    logic [7:0] sc;
  } tod_t;

  typedef struct packed {
    logic [7:0] cent;
    logic [7:0] yr;
    logic [7:0] mon;
    logic [7:0] dt;
    logic [2:0] wd;
  } cal_t;

  localparam cal_t CAL_RESET = '{cent: 8'h19, yr: 8'h00, mon: 8'h01, dt: 8'h01, wd: 3'd1};

  function automatic logic digits_ok(input logic [7:0] v);
    return (v[7:4] <= 4'd9) && (v[3:0] <= 4'd9);
  endfunction

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // binary year mod 4 equals (2*tens + ones) mod 4
  function automatic logic leap_year(input logic [7:0] cent, input logic [7:0] yr);
    logic [5:0] s;
    s = {1'b0, yr[7:4], 1'b0} + {2'b00, yr[3:0]};
    return (s[1:0] == 2'b00) && !(cent == 8'h19 && yr == 8'h00);
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] mon, input logic leap);
    case (mon)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic logic time_ok(input tod_t t);
    return digits_ok(t.sc) && digits_ok(t.mn) && digits_ok(t.hr) &&
           (t.sc <= 8'h59) && (t.mn <= 8'h59) && (t.hr <= 8'h23);
  endfunction

  function automatic logic cal_ok(input cal_t c);
    logic dig;
    dig = digits_ok(c.cent) && digits_ok(c.yr) && digits_ok(c.mon) && digits_ok(c.dt);
    return dig && (c.cent == 8'h19 || c.cent == 8'h20) &&
           (c.mon >= 8'h01) && (c.mon <= 8'h12) && (c.wd != 3'd0) &&
           (c.dt >= 8'h01) && (c.dt <= month_len(c.mon, leap_year(c.cent, c.yr)));
  endfunction

  function automatic tod_t unpack_tod(input logic [31:0] w);
    return '{hr: {2'b00, w[21:16]}, mn: {1'b0, w[14:8]}, sc: {1'b0, w[6:0]}};
  endfunction

  function automatic logic [31:0] pack_tod(input tod_t t);
    return {10'b0, t.hr[5:0], 1'b0, t.mn[6:0], 1'b0, t.sc[6:0]};
  endfunction

  function automatic cal_t unpack_cal(input logic [31:0] w);
    return '{cent: {1'b0, w[6:0]}, yr: w[15:8], mon: {3'b000, w[20:16]},
             dt: {2'b00, w[29:24]}, wd: w[23:21]};
  endfunction

  function automatic logic [31:0] pack_cal(input cal_t c);
    return {2'b00, c.dt[5:0], c.wd, c.mon[4:0], c.yr, 1'b0, c.cent[6:0]};
  endfunction

endpackage

// File: rtl/rtc_update_hs.sv
module rtc_update_hs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       ctrl_we,
  input  logic [1:0] ctrl_d,
  input  logic       clr_we,
  input  logic [2:0] clr_d,
  output logic [1:0] req,
  output logic       hold,
  output logic       ack,
  output logic       sec_flag,
  output logic       freeze_evt
);
  logic hold_q;
  logic any_req;

  assign any_req    = |req;
  assign hold       = hold_q & any_req;
  assign freeze_evt = tick & any_req & ~hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req      <= 2'b00;
      hold_q   <= 1'b0;
      ack      <= 1'b0;
      sec_flag <= 1'b0;
    end else begin
      if (ctrl_we) req <= ctrl_d;
      hold_q   <= any_req & (hold_q | tick);
      ack      <= freeze_evt | (ack & ~(clr_we & clr_d[0]));
      sec_flag <= tick | (sec_flag & ~(clr_we & clr_d[2]));
    end
  end

  // R5
  ack_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack) |-> $past(tick));
  // R10
  sec_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> sec_flag);
endmodule

// File: rtl/rtc_tod_counter.sv
module rtc_tod_counter
  import rtc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic load,
  input  tod_t load_val,
  output tod_t tod,
  output logic day_wrap
);
  tod_t tod_q;
  logic sc_end, mn_end, hr_end;

  assign sc_end   = (tod_q.sc == 8'h59);
  assign mn_end   = (tod_q.mn == 8'h59);
  assign hr_end   = (tod_q.hr == 8'h23);
  assign day_wrap = step & sc_end & mn_end & hr_end;
  assign tod      = tod_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tod_q <= '0;
    end else if (load) begin
      tod_q <= load_val;
    end else if (step) begin
      tod_q.sc <= sc_end ? 8'h00 : bcd_inc(tod_q.sc);
      if (sc_end) begin
        tod_q.mn <= mn_end ? 8'h00 : bcd_inc(tod_q.mn);
        if (mn_end) tod_q.hr <= hr_end ? 8'h00 : bcd_inc(tod_q.hr);
      end
    end
  end

  // R7
  tod_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    time_ok(tod_q));
  // R2
  tod_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> $stable(tod_q));
endmodule

// File: rtl/rtc_cal_counter.sv
module rtc_cal_counter
  import rtc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic load,
  input  cal_t load_val,
  output cal_t cal
);
  cal_t cal_q;
  logic dt_end, mon_end, yr_end;

  assign dt_end  = (cal_q.dt == month_len(cal_q.mon, leap_year(cal_q.cent, cal_q.yr)));
  assign mon_end = (cal_q.mon == 8'h12);
  assign yr_end  = (cal_q.yr == 8'h99);
  assign cal     = cal_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cal_q <= CAL_RESET;
    end else if (load) begin
      cal_q <= load_val;
    end else if (step) begin
      cal_q.wd <= (cal_q.wd == 3'd7) ? 3'd1 : cal_q.wd + 3'd1;
      if (!dt_end) begin
        cal_q.dt <= bcd_inc(cal_q.dt);
      end else begin
        cal_q.dt <= 8'h01;
        if (!mon_end) begin
          cal_q.mon <= bcd_inc(cal_q.mon);
        end else begin
          cal_q.mon <= 8'h01;
          if (!yr_end) begin
            cal_q.yr <= bcd_inc(cal_q.yr);
          end else begin
            cal_q.yr   <= 8'h00;
            cal_q.cent <= (cal_q.cent == 8'h20) ? 8'h19 : bcd_inc(cal_q.cent);
          end
        end
      end
    end
  end

  // R8
  cal_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_ok(cal_q));
  // R3
  cal_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> $stable(cal_q));
endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata
);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(OFS_MODE);
  localparam logic [ADDR_W-1:0] A_TOD   = ADDR_W'(OFS_TOD);
  localparam logic [ADDR_W-1:0] A_CAL   = ADDR_W'(OFS_CAL);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_SCLR  = ADDR_W'(OFS_SCLR);
  localparam logic [ADDR_W-1:0] A_VALID = ADDR_W'(OFS_VALID);

  logic [1:0] req;
  logic       hold, ack, sec_flag, freeze_evt;
  logic       wr_ctrl, wr_tod, wr_cal, wr_sclr;
  logic       tod_wr_ok, cal_wr_ok, tod_in_ok, cal_in_ok;
  logic       tod_load, cal_load, step, day_wrap;
  logic       bad_tod, bad_cal;
  tod_t       tod, tod_in;
  cal_t       cal, cal_in;

  assign wr_ctrl = bus_we && (bus_addr == A_CTRL);
  assign wr_tod  = bus_we && (bus_addr == A_TOD);
  assign wr_cal  = bus_we && (bus_addr == A_CAL);
  assign wr_sclr = bus_we && (bus_addr == A_SCLR);

  assign tod_in    = unpack_tod(bus_wdata);
  assign cal_in    = unpack_cal(bus_wdata);
  assign tod_in_ok = time_ok(tod_in);
  assign cal_in_ok = cal_ok(cal_in);
  assign tod_wr_ok = wr_tod & hold & req[0];
  assign cal_wr_ok = wr_cal & hold & req[1];
  assign tod_load  = tod_wr_ok & tod_in_ok;
  assign cal_load  = cal_wr_ok & cal_in_ok;
  assign step      = tick_1hz & ~hold;

  rtc_update_hs u_hs (
    .clk(clk), .rst_n(rst_n), .tick(tick_1hz),
    .ctrl_we(wr_ctrl), .ctrl_d(bus_wdata[1:0]),
    .clr_we(wr_sclr), .clr_d(bus_wdata[2:0]),
    .req(req), .hold(hold), .ack(ack), .sec_flag(sec_flag), .freeze_evt(freeze_evt)
  );

  rtc_tod_counter u_tod (
    .clk(clk), .rst_n(rst_n), .step(step), .load(tod_load),
    .load_val(tod_in), .tod(tod), .day_wrap(day_wrap)
  );

  rtc_cal_counter u_cal (
    .clk(clk), .rst_n(rst_n), .step(day_wrap), .load(cal_load),
    .load_val(cal_in), .cal(cal)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bad_tod <= 1'b0;
      bad_cal <= 1'b0;
    end else begin
      if (tod_wr_ok) bad_tod <= ~tod_in_ok;
      if (cal_wr_ok) bad_cal <= ~cal_in_ok;
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = {30'b0, req};
      A_MODE:  bus_rdata = 32'b0;
      A_TOD:   bus_rdata = pack_tod(tod);
      A_CAL:   bus_rdata = pack_cal(cal);
      A_STAT:  bus_rdata = {29'b0, sec_flag, 1'b0, ack};
      A_VALID: bus_rdata = {30'b0, bad_cal, bad_tod};
      default: bus_rdata = 32'b0;
    endcase
  end

  // R5
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !tod_load) |=> $stable(tod));
  // R6
  tod_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_tod && !(hold && req[0]) && !step) |=> $stable(tod));
  // R5
  ack_follows_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_evt |=> ack);
endmodule

// File: tb/test_bcd_rtc_core.sv
`timescale 1ns/1ps
module test_bcd_rtc_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bcd_rtc_core #(.ADDR_W(8)) i_bcd_rtc_core (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  // ---------------- reference model ----------------
  int m_sc, m_mn, m_hr, m_wd, m_dt, m_mo, m_yr;
  logic [1:0] m_req;
  bit m_holdq, m_ack, m_secf, m_bt, m_bc;

  function automatic logic [7:0] bcd(input int v);
    logic [7:0] r;
    r[7:4] = 4'(v / 10);
    r[3:0] = 4'(v % 10);
    return r;
  endfunction

  function automatic int dig(input logic [7:0] b);
    if (b[7:4] > 4'd9 || b[3:0] > 4'd9) return -1;
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic int mdays(input int mo, input int y);
    bit leap;
    leap = (y % 4 == 0) && (y != 1900);
    if (mo == 2) return leap ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [31:0] mk_tod(input int h, input int m, input int s);
    logic [7:0] bh, bm, bs;
    bh = bcd(h); bm = bcd(m); bs = bcd(s);
    return {10'b0, bh[5:0], 1'b0, bm[6:0], 1'b0, bs[6:0]};
  endfunction

  function automatic logic [31:0] mk_cal(input int d, input int wd, input int mo, input int y);
    logic [7:0] bd, bmo, by, bc;
    logic [2:0] w3;
    bd = bcd(d); bmo = bcd(mo); by = bcd(y % 100); bc = bcd(y / 100);
    w3 = 3'(wd);
    return {2'b00, bd[5:0], w3, bmo[4:0], by, 1'b0, bc[6:0]};
  endfunction

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    case (a)
      8'h00: return {30'b0, m_req};
      8'h08: return mk_tod(m_hr, m_mn, m_sc);
      8'h0C: return mk_cal(m_dt, m_wd, m_mo, m_yr);
      8'h18: return {29'b0, m_secf, 1'b0, m_ack};
      8'h2C: return {30'b0, m_bc, m_bt};
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_advance();
    m_sc++;
    if (m_sc == 60) begin
      m_sc = 0; m_mn++;
      if (m_mn == 60) begin
        m_mn = 0; m_hr++;
        if (m_hr == 24) begin
          m_hr = 0;
          m_wd = (m_wd == 7) ? 1 : m_wd + 1;
          m_dt++;
          if (m_dt > mdays(m_mo, m_yr)) begin
            m_dt = 1; m_mo++;
            if (m_mo == 13) begin
              m_mo = 1;
              m_yr = (m_yr == 2099) ? 1900 : m_yr + 1;
            end
          end
        end
      end
    end
  endtask

  task automatic model_load_tod(input logic [31:0] w);
    int s, m, h;
    s = dig({1'b0, w[6:0]}); m = dig({1'b0, w[14:8]}); h = dig({2'b0, w[21:16]});
    if (s >= 0 && m >= 0 && h >= 0 && s < 60 && m < 60 && h < 24) begin
      m_sc = s; m_mn = m; m_hr = h; m_bt = 0;
    end else m_bt = 1;
  endtask

  task automatic model_load_cal(input logic [31:0] w);
    int c, y, mo, d, wd;
    c = dig({1'b0, w[6:0]}); y = dig(w[15:8]); mo = dig({3'b0, w[20:16]});
    d = dig({2'b0, w[29:24]}); wd = int'(w[23:21]);
    if ((c == 19 || c == 20) && y >= 0 && mo >= 1 && mo <= 12 && wd >= 1 &&
        d >= 1 && d <= mdays(mo, c * 100 + y)) begin
      m_yr = c * 100 + y; m_mo = mo; m_dt = d; m_wd = wd; m_bc = 0;
    end else m_bc = 1;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sc = 0; m_mn = 0; m_hr = 0; m_wd = 1; m_dt = 1; m_mo = 1; m_yr = 1900;
      m_req = 0; m_holdq = 0; m_ack = 0; m_secf = 0; m_bt = 0; m_bc = 0;
    end else begin
      bit frozen, nh;
      frozen = m_holdq && (m_req != 0);
      if (tick && !frozen) model_advance();
      if (bus_we && bus_addr == 8'h08 && frozen && m_req[0]) model_load_tod(bus_wdata);
      if (bus_we && bus_addr == 8'h0C && frozen && m_req[1]) model_load_cal(bus_wdata);
      nh = (m_req != 0) && (m_holdq || tick);
      if (tick && m_req != 0 && !m_holdq) m_ack = 1;
      else if (bus_we && bus_addr == 8'h1C && bus_wdata[0]) m_ack = 0;
      if (tick) m_secf = 1;
      else if (bus_we && bus_addr == 8'h1C && bus_wdata[2]) m_secf = 0;
      m_holdq = nh;
      if (bus_we && bus_addr == 8'h00) m_req = bus_wdata[1:0];
    end
  end

  // ---------------- checking ----------------
  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, bus_addr, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [7:0] a);
    case (a)
      8'h00: return "R5";
      8'h08: return "R2";
      8'h0C: return "R3";
      8'h18: return "R10";
      8'h2C: return "R7";
      default: return "R1";
    endcase
  endfunction

  task automatic cyc(input logic [7:0] a, input logic we, input logic [31:0] d, input logic tk);
    bus_addr = a; bus_we = we; bus_wdata = d; tick = tk;
    @(posedge clk);
    @(negedge clk);
    check(tag_of(a), bus_rdata, exp_rd(a));
  endtask

  task automatic rd(input logic [7:0] a);
    cyc(a, 1'b0, 32'h0, 1'b0);
  endtask

  task automatic roll_case(input logic [31:0] t, input logic [31:0] c,
                           input logic [31:0] exp_c, input string tag);
    cyc(8'h00, 1'b1, 32'h3, 1'b0);
    cyc(8'h18, 1'b0, 32'h0, 1'b1);
    cyc(8'h08, 1'b1, t, 1'b0);
    cyc(8'h0C, 1'b1, c, 1'b0);
    cyc(8'h00, 1'b1, 32'h0, 1'b0);
    cyc(8'h1C, 1'b1, 32'h1, 1'b0);
    cyc(8'h0C, 1'b0, 32'h0, 1'b1);
    check(tag, bus_rdata, exp_c);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    rd(8'h08); check("R1", bus_rdata, 32'h0000_0000);
    rd(8'h0C); check("R1", bus_rdata, 32'h0121_0019);
    rd(8'h18); check("R1", bus_rdata, 32'h0);
    rd(8'h2C); check("R1", bus_rdata, 32'h0);
    rd(8'h00); check("R1", bus_rdata, 32'h0);

    // R2 counting through the minute carry
    for (int i = 0; i < 70; i++) begin
      cyc(8'h08, 1'b0, 32'h0, 1'b1);
      rd(8'h0C);
      rd(8'h18);
    end
    rd(8'h08); check("R2", bus_rdata, mk_tod(0, 1, 10));

    // R6 writes without a freeze are ignored
    cyc(8'h08, 1'b1, mk_tod(12, 34, 56), 1'b0);
    check("R6", bus_rdata, mk_tod(0, 1, 10));
    cyc(8'h00, 1'b1, 32'h1, 1'b0);
    cyc(8'h18, 1'b0, 32'h0, 1'b1);
    cyc(8'h0C, 1'b1, mk_cal(5, 2, 6, 2010), 1'b0);
    check("R6", bus_rdata, mk_cal(1, 1, 1, 1900));
    cyc(8'h00, 1'b1, 32'h0, 1'b0);
    cyc(8'h1C, 1'b1, 32'h1, 1'b0);

    // R5 freeze handshake
    cyc(8'h00, 1'b1, 32'h3, 1'b0);
    rd(8'h18); check("R5", bus_rdata & 32'h1, 32'h0);
    cyc(8'h18, 1'b0, 32'h0, 1'b1);
    check("R5", bus_rdata & 32'h1, 32'h1);
    cyc(8'h08, 1'b0, 32'h0, 1'b1);
    check("R5", bus_rdata, mk_tod(0, 1, 12));

    // R7 / R8 load and validity
    cyc(8'h08, 1'b1, mk_tod(23, 59, 58), 1'b0);
    cyc(8'h0C, 1'b1, mk_cal(31, 7, 12, 1999), 1'b0);
    rd(8'h2C); check("R7", bus_rdata, 32'h0);
    cyc(8'h08, 1'b1, 32'h0024_5000, 1'b0);
    check("R7", bus_rdata, mk_tod(23, 59, 58));
    rd(8'h2C); check("R7", bus_rdata, 32'h1);
    cyc(8'h08, 1'b1, 32'h0000_005A, 1'b0);
    check("R7", bus_rdata, mk_tod(23, 59, 58));
    cyc(8'h0C, 1'b1, mk_cal(30, 1, 2, 2024), 1'b0);
    check("R8", bus_rdata, mk_cal(31, 7, 12, 1999));
    rd(8'h2C); check("R8", bus_rdata, 32'h3);
    cyc(8'h0C, 1'b1, mk_cal(1, 1, 1, 2100), 1'b0);
    check("R8", bus_rdata, mk_cal(31, 7, 12, 1999));
    cyc(8'h0C, 1'b1, mk_cal(29, 1, 2, 1900), 1'b0);
    check("R8", bus_rdata, mk_cal(31, 7, 12, 1999));
    cyc(8'h08, 1'b1, mk_tod(23, 59, 58), 1'b0);
    rd(8'h2C); check("R7", bus_rdata, 32'h2);
    cyc(8'h0C, 1'b1, mk_cal(31, 7, 12, 1999), 1'b0);
    rd(8'h2C); check("R8", bus_rdata, 32'h0);

    // R9 resume, R3 year and century carry, weekday 7 -> 1
    cyc(8'h00, 1'b1, 32'h0, 1'b0);
    cyc(8'h1C, 1'b1, 32'h5, 1'b0);
    rd(8'h18); check("R10", bus_rdata, 32'h0);
    cyc(8'h08, 1'b0, 32'h0, 1'b1);
    check("R9", bus_rdata, mk_tod(23, 59, 59));
    cyc(8'h0C, 1'b0, 32'h0, 1'b1);
    check("R3", bus_rdata, mk_cal(1, 1, 1, 2000));

    // R4 leap handling, R3 month lengths and the range wrap
    roll_case(mk_tod(23, 59, 59), mk_cal(28, 3, 2, 2024), mk_cal(29, 4, 2, 2024), "R4");
    roll_case(mk_tod(23, 59, 59), mk_cal(29, 4, 2, 2024), mk_cal(1, 5, 3, 2024), "R4");
    roll_case(mk_tod(23, 59, 59), mk_cal(28, 3, 2, 1900), mk_cal(1, 4, 3, 1900), "R4");
    roll_case(mk_tod(23, 59, 59), mk_cal(28, 2, 2, 2023), mk_cal(1, 3, 3, 2023), "R4");
    roll_case(mk_tod(23, 59, 59), mk_cal(30, 7, 4, 2031), mk_cal(1, 1, 5, 2031), "R3");
    roll_case(mk_tod(23, 59, 59), mk_cal(31, 4, 12, 2099), mk_cal(1, 5, 1, 1900), "R3");

    // R10 flag clear, set wins over clear
    cyc(8'h18, 1'b0, 32'h0, 1'b1);
    cyc(8'h1C, 1'b1, 32'h4, 1'b1);
    rd(8'h18); check("R10", bus_rdata & 32'h4, 32'h4);
    cyc(8'h1C, 1'b1, 32'h4, 1'b0);
    rd(8'h18); check("R10", bus_rdata & 32'h4, 32'h0);
    rd(8'h04); check("R1", bus_rdata, 32'h0);

    for (int i = 0; i < 40; i++) begin
      cyc(8'h08, 1'b0, 32'h0, (i % 3) == 0);
      rd(8'h0C);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule